// File: doc/BRIEF.md
# Seeded BCD Watchdog Counter

This block is a software watchdog whose timeout is held as four BCD digits split over two bytes: the low byte carries hundredths of a second and the high byte carries whole seconds, so timeouts run from 0.01 s to 99.99 s in 10 ms steps. A one-cycle `tickEn` pulse, expected at 100 Hz, decrements the count by one while the watchdog is enabled and armed. When the count reaches zero the block raises a sticky alarm flag and, if the reset-drive control bit is set, a one-cycle reset request for a separate reset controller. Pulse length and serial access are handled elsewhere.

Each byte write updates a seed register and restarts the live counter from that seed. Each byte read returns the count as it stood in that cycle and also restarts the counter from the seed. Any access therefore services the watchdog. A seed of all zeros disarms the counter without raising the flag. With the enable bit cleared the counter never moves, so the two bytes serve as 16 bits of ordinary storage.

Top module: `wd_bcd_watchdog`

## Requirements
- R1: After reset the control state `ctrlState` is 2'b00 (bit 1 enable, bit 0 reset-drive), and `alarmFlag` and `resetReq` are 0.
- R2: A write with `wrSel`=0 loads `wrData` into the hundredths byte, and with `wrSel`=1 into the seconds byte. The value goes into both the seed and the live count. The other byte keeps its seed value.
- R3: A read (`rdEn`, `rdSel` choosing the byte as in R2) places that byte of the count as it stood in the read cycle on `rdData` one clock later. `rdData` then holds until the next read.
- R4: While enabled and armed, each `tickEn` cycle lowers the count by exactly one in four-digit BCD with borrow between digits.
- R5: The tick that brings the count from 0x0001 to 0x0000 sets `alarmFlag` one clock later, and the count stays at 0x0000.
- R6: At that expiry, `resetReq` is high for exactly one cycle, and only if reset-drive is 1. With reset-drive 0, only the flag is set.
- R7: A write that leaves the seed at all zeros disarms the counter. Ticks then neither set the flag nor request a reset.
- R8: With enable 0, ticks leave the count unchanged, and both bytes read back what was written.
- R9: `alarmFlag` stays 1 until a flag write with `flagWrData`=0. A flag write with `flagWrData`=1 leaves the flag unchanged.
- R10: Any read or write reloads the count from the seed and restarts the timeout. This access takes priority over a tick in the same cycle.
- R11: After expiry the counter does not reload or fire again until it is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | 100 Hz single-cycle count enable |
| wrEn | input | 1 | Count byte write strobe |
| wrSel | input | 1 | Byte select for write (0 hundredths, 1 seconds) |
| wrData | input | 8 | BCD byte to write |
| rdEn | input | 1 | Count byte read strobe |
| rdSel | input | 1 | Byte select for read |
| rdData | output | 8 | Latched count byte |
| ctrlWrEn | input | 1 | Control write strobe |
| ctrlWrData | input | 2 | Bit 1 enable, bit 0 reset-drive |
| flagWrEn | input | 1 | Alarm flag write strobe |
| flagWrData | input | 1 | Flag write value (only 0 has effect) |
| ctrlState | output | 2 | Current control bits |
| alarmFlag | output | 1 | Sticky expiry flag |
| resetReq | output | 1 | One-cycle reset request |

## Verification
The assertions rely on every byte written while the watchdog is enabled being valid BCD, and on `tickEn` never sharing a cycle with an access that the bench is timing. The bench meets the first condition by writing only values converted from integers 0 to 9999 whenever enable is set. It writes arbitrary bit patterns only in the storage sweep, where enable is 0 and the decrementer never runs. It drives ticks as isolated pulses separated by idle cycles, so each expected count is the seed minus the number of pulses issued.

// File: rtl/wd_bcd_pkg.sv
package wd_bcd_pkg;
  typedef struct packed {
    logic loadSeed;
    logic reload;
    logic decrement;
    logic latchRead;
  } wdStrobe_t;
endpackage

// File: rtl/wd_bcd_datapath.sv
module wd_bcd_datapath
  import wd_bcd_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wdStrobe_t                     strobe,
  input  logic [$clog2(DIGITS/2)-1:0]   wrSel,
  input  logic [7:0]                    wrData,
  input  logic [$clog2(DIGITS/2)-1:0]   rdSel,
  output logic [7:0]                    rdData,
  output logic                          countIsOne,
  output logic                          countZero,
  output logic                          seedZero,
  output logic                          wrSeedZero
);
  localparam int BYTES = DIGITS / 2;
  localparam int WIDTH = DIGITS * 4;

  logic [WIDTH-1:0] seedQ, countQ, seedMerge, countDec;
  logic [DIGITS:0]  borrow;
  logic [7:0]       cntBytes [BYTES];

  assign borrow[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] digitCur;
    assign digitCur = countQ[d*4 +: 4];
    assign borrow[d+1] = borrow[d] && (digitCur == 4'd0);
    assign countDec[d*4 +: 4] = !borrow[d] ? digitCur :
                                (digitCur == 4'd0) ? 4'd9 : digitCur - 4'd1;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign seedMerge[b*8 +: 8] = (wrSel == b[$clog2(BYTES)-1:0]) ? wrData : seedQ[b*8 +: 8];
    assign cntBytes[b] = countQ[b*8 +: 8];
  end

  assign countIsOne = (countQ == WIDTH'(1));
  assign countZero  = (countQ == '0);
  assign seedZero   = (seedQ == '0);
  assign wrSeedZero = (seedMerge == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedQ  <= '0;
      countQ <= '0;
      rdData <= '0;
    end else begin
      if (strobe.latchRead) rdData <= cntBytes[rdSel];
      if (strobe.loadSeed) begin
        seedQ  <= seedMerge;
        countQ <= seedMerge;
      end else if (strobe.reload) begin
        countQ <= seedQ;
      end else if (strobe.decrement) begin
        countQ <= countDec;
      end
    end
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decrement |-> !countZero);

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadSeed || strobe.reload || strobe.decrement) |=> $stable(countQ));

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSeed |=> (countQ == seedQ));
endmodule

// File: rtl/wd_bcd_control.sv
module wd_bcd_control
  import wd_bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       ctrlWrEn,
  input  logic [1:0] ctrlWrData,
  input  logic       flagWrEn,
  input  logic       flagWrData,
  input  logic       countIsOne,
  input  logic       countZero,
  input  logic       seedZero,
  input  logic       wrSeedZero,
  output wdStrobe_t  strobe,
  output logic [1:0] ctrlState,
  output logic       alarmFlag,
  output logic       resetReq
);
  logic wdEnable, wdDrive, armed, expire;

  assign strobe.loadSeed  = wrEn;
  assign strobe.reload    = rdEn && !wrEn;
  assign strobe.latchRead = rdEn;
  assign strobe.decrement = tickEn && wdEnable && armed && !wrEn && !rdEn;
  assign expire           = strobe.decrement && countIsOne;
  assign ctrlState        = {wdEnable, wdDrive};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdEnable  <= 1'b0;
      wdDrive   <= 1'b0;
      armed     <= 1'b0;
      alarmFlag <= 1'b0;
      resetReq  <= 1'b0;
    end else begin
      if (ctrlWrEn) begin
        wdEnable <= ctrlWrData[1];
        wdDrive  <= ctrlWrData[0];
      end
      if (wrEn)        armed <= !wrSeedZero;
      else if (rdEn)   armed <= !seedZero;
      else if (expire) armed <= 1'b0;
      if (expire) alarmFlag <= 1'b1;
      else if (flagWrEn && !flagWrData) alarmFlag <= 1'b0;
      resetReq <= expire && wdDrive;
    end
  end

  // R6
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> alarmFlag);

  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmFlag && !(flagWrEn && !flagWrData) |=> alarmFlag);

  // R7
  armed_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> !countZero);

  // R11
  no_refire_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(resetReq) && !$past(wrEn) && !$past(rdEn) |-> !resetReq);
endmodule

// File: rtl/wd_bcd_watchdog.sv
module wd_bcd_watchdog
  import wd_bcd_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tickEn,
  input  logic                        wrEn,
  input  logic [$clog2(DIGITS/2)-1:0] wrSel,
  input  logic [7:0]                  wrData,
  input  logic                        rdEn,
  input  logic [$clog2(DIGITS/2)-1:0] rdSel,
  output logic [7:0]                  rdData,
  input  logic                        ctrlWrEn,
  input  logic [1:0]                  ctrlWrData,
  input  logic                        flagWrEn,
  input  logic                        flagWrData,
  output logic [1:0]                  ctrlState,
  output logic                        alarmFlag,
  output logic                        resetReq
);
  wdStrobe_t strobe;
  logic countIsOne, countZero, seedZero, wrSeedZero;

  wd_bcd_control ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .countIsOne(countIsOne), .countZero(countZero),
    .seedZero(seedZero), .wrSeedZero(wrSeedZero),
    .strobe(strobe), .ctrlState(ctrlState),
    .alarmFlag(alarmFlag), .resetReq(resetReq)
  );

  wd_bcd_datapath #(.DIGITS(DIGITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .countIsOne(countIsOne), .countZero(countZero),
    .seedZero(seedZero), .wrSeedZero(wrSeedZero)
  );
endmodule

// File: tb/wd_bcd_watchdog_tb.sv
module wd_bcd_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic tickEn = 0, wrEn = 0, rdEn = 0, ctrlWrEn = 0, flagWrEn = 0, flagWrData = 0;
  logic wrSel = 0, rdSel = 0;
  logic [7:0] wrData = 0;
  logic [1:0] ctrlWrData = 0;
  logic [7:0] rdData;
  logic [1:0] ctrlState;
  logic alarmFlag, resetReq;

  int total = 0, bad = 0, pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wd_bcd_watchdog dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .ctrlState(ctrlState), .alarmFlag(alarmFlag),
    .resetReq(resetReq)
  );

  always @(negedge clk) if (rstN && resetReq) pulses++;

  function automatic logic [15:0] toBcd(int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeByte(logic sel, logic [7:0] v);
    wrEn = 1; wrSel = sel; wrData = v;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic writeWord(logic [15:0] v);
    writeByte(1'b1, v[15:8]);
    writeByte(1'b0, v[7:0]);
  endtask

  task automatic readByte(logic sel, output logic [7:0] v);
    rdEn = 1; rdSel = sel;
    @(negedge clk); rdEn = 0; v = rdData;
  endtask

  task automatic setCtrl(logic [1:0] v);
    ctrlWrEn = 1; ctrlWrData = v;
    @(negedge clk); ctrlWrEn = 0;
  endtask

  task automatic writeFlag(logic v);
    flagWrEn = 1; flagWrData = v;
    @(negedge clk); flagWrEn = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1; @(negedge clk); tickEn = 0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 19000) @(negedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, held;
    int seeds [7] = '{5, 10, 100, 1000, 9999, 1234, 60};
    repeat (3) @(negedge clk);
    check("R1 ctrl", ctrlState, 0);
    check("R1 flag", alarmFlag, 0);
    check("R1 req", resetReq, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 ctrl after release", ctrlState, 0);

    // R8 / R2 storage sweep with enable cleared
    for (int k = 0; k < 16; k++) begin
      logic [15:0] v;
      v = 16'(k * 4099) ^ 16'h5a3c;
      writeWord(v);
      ticks(3);
      readByte(1'b0, r); check("R8 low byte", r, v[7:0]);
      readByte(1'b1, r); check("R8 high byte", r, v[15:8]);
    end
    check("R8 no flag", alarmFlag, 0);

    // R4 countdown sweep, enable on, no reset drive
    setCtrl(2'b10);
    check("R4 ctrl", ctrlState, 2);
    foreach (seeds[s]) begin
      int ns [4];
      ns = '{0, 1, seeds[s] / 2, seeds[s] - 1};
      foreach (ns[j]) begin
        logic [15:0] e;
        e = toBcd(seeds[s] - ns[j]);
        writeWord(toBcd(seeds[s])); ticks(ns[j]);
        readByte(1'b0, r); check("R4 low digits", r, e[7:0]);
        writeWord(toBcd(seeds[s])); ticks(ns[j]);
        readByte(1'b1, r); check("R4 high digits", r, e[15:8]);
      end
    end
    check("R4 no expiry", alarmFlag, 0);

    // R3 read data held
    writeWord(16'h0042); ticks(2);
    readByte(1'b0, held);
    check("R3 latched count", held, 8'h40);
    ticks(4);
    check("R3 rdData held", rdData, 8'h40);

    // R9 writing 1 to clear flag has no effect
    writeFlag(1'b1);
    check("R9 write one on clear", alarmFlag, 0);

    // R5 R6 R11 expiry with reset drive
    setCtrl(2'b11);
    pulses = 0;
    writeWord(16'h0003);
    ticks(2);
    check("R5 not yet", alarmFlag, 0);
    check("R6 not yet", pulses, 0);
    ticks(1);
    check("R5 flag set", alarmFlag, 1);
    check("R6 one pulse", pulses, 1);
    ticks(5);
    check("R11 no refire", pulses, 1);
    readByte(1'b0, r); check("R5 holds zero low", r, 0);
    readByte(1'b1, r); check("R11 no reload high", r, 0);
    writeFlag(1'b1);
    check("R9 write one keeps", alarmFlag, 1);
    ticks(3);
    check("R11 rearmed by read", pulses, 2);
    writeFlag(1'b0);
    check("R9 clear", alarmFlag, 0);

    // R6 reset drive off
    setCtrl(2'b10);
    pulses = 0;
    writeWord(16'h0002); ticks(2);
    check("R6 flag only", alarmFlag, 1);
    check("R6 no pulse", pulses, 0);
    writeFlag(1'b0);

    // R7 all-zero seed disarms
    setCtrl(2'b11);
    pulses = 0;
    writeWord(16'h0000); ticks(20);
    check("R7 no flag", alarmFlag, 0);
    check("R7 no pulse", pulses, 0);
    readByte(1'b0, r); check("R7 count zero", r, 0);

    // R10 restart by read and by write
    setCtrl(2'b10);
    writeWord(16'h0005); ticks(3);
    readByte(1'b0, r); check("R10 read value", r, 8'h02);
    ticks(4); check("R10 read restarts", alarmFlag, 0);
    ticks(1); check("R10 expiry after read", alarmFlag, 1);
    writeFlag(1'b0);
    writeByte(1'b0, 8'h05); ticks(4);
    writeByte(1'b0, 8'h05); ticks(4);
    check("R10 write restarts", alarmFlag, 0);
    ticks(1); check("R10 expiry after write", alarmFlag, 1);
    // R10 access wins over a tick in the same cycle
    writeFlag(1'b0);
    writeWord(16'h0003); ticks(1);
    tickEn = 1; rdEn = 1; rdSel = 0;
    @(negedge clk); tickEn = 0; rdEn = 0;
    check("R10 read same cycle as tick", rdData, 8'h02);
    ticks(2); check("R10 tick ignored", alarmFlag, 0);
    ticks(1); check("R10 expiry timing", alarmFlag, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule